// File: doc/BRIEF.md
# CAN Error and Status Register Block

This block sits between the protocol engine of a CAN controller and a CPU. The engine reports bus errors as one-cycle pulses. It also drives level signals for the warning limits, the bus-off state, idle, transfer activity and the fault-confinement state, and it supplies both error counters. The block records the error pulses in sticky flags. It keeps four interrupt flags and presents two 32-bit words on a simple single-cycle register bus.

Bits are numbered with bit 0 as the most significant bit of the word, so word bit n is `bus_rdata[31-n]`. The error/status word is at offset 0x20. Reading it returns the recorded error history and clears that history. The counter word is at offset 0x1C and is read-only. The four interrupt flags are cleared only by writing ones. Each flag drives its own interrupt line with no masking.

A bus transfer completes in every cycle where `bus_sel` is high: it is a write when `bus_wr` is high and a read otherwise. Read data is valid in the same cycle, and any clear caused by a read takes effect at the clock edge that ends that cycle.

Top module: `can_err_regs`

## Requirements
- R1: After reset every stored bit is zero: both words read zero with zero status and counter inputs, and all four interrupt outputs are low.
- R2: A pulse on `err_evt[i]` (i = 0..5) sets error/status bit 16+i, which is `bus_rdata[15-i]`. The bit stays set until the next completed read of the error/status word. The meanings are recessive-bit, dominant-bit, acknowledge, CRC, form and stuffing error, in that order.
- R3: A completed read of the error/status word returns the value held before the clear, then clears bits 16 to 23.
- R4: An error event or an active warning level in the same cycle as a clearing read wins: the bit is set for the following read.
- R5: Bit 22 (`bus_rdata[9]`) is set while `tx_warn` is high and bit 23 (`bus_rdata[8]`) is set while `rx_warn` is high. Each stays set until the next clearing read.
- R6: The live status fields read as follows. Bit 24 (`bus_rdata[7]`) is `idle`. Bit 25 (`bus_rdata[6]`) is `txrx`. Bits 26..27 (`bus_rdata[5:4]`) are `fault_state[1:0]`. Bits 0..13, bit 28 and bit 31 read zero.
- R7: The counter word at 0x1C holds `rx_err_cnt` in bits 16..23 (`bus_rdata[15:8]`) and `tx_err_cnt` in bits 24..31 (`bus_rdata[7:0]`). The rest reads zero, and reading it clears nothing.
- R8: The error interrupt flag at bit 30 (`bus_rdata[1]`) sets in the cycle after any error pulse. `irq_err` is high whenever the flag is set.
- R9: Interrupt flags for the transmit warning (bit 14, `bus_rdata[17]`), the receive warning (bit 15, `bus_rdata[16]`) and bus-off (bit 29, `bus_rdata[2]`) set on a rising edge of `tx_warn`, `rx_warn` or `bus_off`. They drive `irq_tx_warn`, `irq_rx_warn` and `irq_bus_off`.
- R10: Writing 1 to an interrupt flag position of the error/status word clears that flag, and writing 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R11: A write to the error/status word leaves bits 16..23 unchanged, and a read of any address other than 0x1C and 0x20 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | A transfer completes this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| err_evt | input | 6 | One-cycle error pulses, index 0 = recessive-bit error |
| tx_warn | input | 1 | Transmit counter above warning limit |
| rx_warn | input | 1 | Receive counter above warning limit |
| bus_off | input | 1 | Node is bus-off |
| idle | input | 1 | Bus idle status |
| txrx | input | 1 | Node transmitting (1) or receiving (0) |
| fault_state | input | 2 | Fault-confinement state |
| rx_err_cnt | input | 8 | Receive error counter |
| tx_err_cnt | input | 8 | Transmit error counter |
| irq_tx_warn | output | 1 | Transmit-warning interrupt |
| irq_rx_warn | output | 1 | Receive-warning interrupt |
| irq_bus_off | output | 1 | Bus-off interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a clearing read in the same cycle as a new error pulse or a still-high warning level. In that case the read must return the old value, and the bit must survive for the next read. A second hard case is a write-one-to-clear that lands in the cycle when its set condition fires. The random phase drives error pulses and reads independently with high rates, so these cycles occur often. Directed steps also force the read-collision case once. Every read is compared against a bench model of the sticky and interrupt state, which the bench updates from the same inputs.

// File: rtl/can_err_regs.sv
module can_err_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] CNT_OFS  = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [5:0]        err_evt,
  input  logic              tx_warn,
  input  logic              rx_warn,
  input  logic              bus_off,
  input  logic              idle,
  input  logic              txrx,
  input  logic [1:0]        fault_state,
  input  logic [7:0]        rx_err_cnt,
  input  logic [7:0]        tx_err_cnt,
  output logic              irq_tx_warn,
  output logic              irq_rx_warn,
  output logic              irq_bus_off,
  output logic              irq_err
);

  localparam int NERR = 6;

  logic [NERR-1:0] err_q;
  logic [1:0]      wrn_q;
  logic            tw_q, rw_q, bo_q, er_q;
  logic            tx_d, rx_d, bo_d;
  logic [31:0]     stat_word, cnt_word;

  wire rd_stat = bus_sel & ~bus_wr & (bus_addr == STAT_OFS);
  wire wr_stat = bus_sel &  bus_wr & (bus_addr == STAT_OFS);
  wire rd_cnt  = bus_sel & ~bus_wr & (bus_addr == CNT_OFS);

  wire clr_tw = wr_stat & bus_wdata[17];
  wire clr_rw = wr_stat & bus_wdata[16];
  wire clr_bo = wr_stat & bus_wdata[2];
  wire clr_er = wr_stat & bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      wrn_q <= '0;
      tw_q  <= 1'b0;
      rw_q  <= 1'b0;
      bo_q  <= 1'b0;
      er_q  <= 1'b0;
      tx_d  <= 1'b0;
      rx_d  <= 1'b0;
      bo_d  <= 1'b0;
    end else begin
      err_q <= (rd_stat ? '0 : err_q) | err_evt;
      wrn_q <= (rd_stat ? 2'b00 : wrn_q) | {tx_warn, rx_warn};
      tw_q  <= (tw_q & ~clr_tw) | (tx_warn & ~tx_d);
      rw_q  <= (rw_q & ~clr_rw) | (rx_warn & ~rx_d);
      bo_q  <= (bo_q & ~clr_bo) | (bus_off & ~bo_d);
      er_q  <= (er_q & ~clr_er) | (|err_evt);
      tx_d  <= tx_warn;
      rx_d  <= rx_warn;
      bo_d  <= bus_off;
    end
  end

  always_comb begin
    stat_word      = '0;
    stat_word[17]  = tw_q;
    stat_word[16]  = rw_q;
    for (int i = 0; i < NERR; i++) stat_word[15-i] = err_q[i];
    stat_word[9:8] = wrn_q;
    stat_word[7]   = idle;
    stat_word[6]   = txrx;
    stat_word[5:4] = fault_state;
    stat_word[2]   = bo_q;
    stat_word[1]   = er_q;
  end

  assign cnt_word  = {16'h0000, rx_err_cnt, tx_err_cnt};
  assign bus_rdata = rd_stat ? stat_word : (rd_cnt ? cnt_word : 32'h0);

  assign irq_tx_warn = tw_q;
  assign irq_rx_warn = rw_q;
  assign irq_bus_off = bo_q;
  assign irq_err     = er_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt))) else $error("sticky"); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && err_evt == '0 && !tx_warn && !rx_warn) |=> (err_q == '0 && wrn_q == 2'b00)) else $error("rdclr"); // R3

  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((err_q & $past(err_q)) == $past(err_q))) else $error("wrkeep"); // R11

  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> irq_err) else $error("errirq"); // R8

  AST_BOFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !bo_d) |=> irq_bus_off) else $error("boff"); // R9

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && err_evt == '0) |=> !irq_err) else $error("w1c"); // R10

  AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[1] && irq_err) |=> irq_err) else $error("w0"); // R10

endmodule

// File: tb/can_err_regs_bench.sv
module can_err_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [5:0]  err_evt = 0;
  logic        tx_warn = 0, rx_warn = 0, bus_off = 0, idle = 0, txrx = 0;
  logic [1:0]  fault_state = 0;
  logic [7:0]  rx_err_cnt = 0, tx_err_cnt = 0;
  logic        irq_tx_warn, irq_rx_warn, irq_bus_off, irq_err;

  int checks = 0, errors = 0;

  logic [5:0] m_err = 0;
  logic       m_txw = 0, m_rxw = 0;
  logic       m_tw = 0, m_rw = 0, m_bo = 0, m_er = 0;
  logic       p_tx = 0, p_rx = 0, p_bo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_regs u_can_err_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_evt(err_evt), .tx_warn(tx_warn), .rx_warn(rx_warn), .bus_off(bus_off),
    .idle(idle), .txrx(txrx), .fault_state(fault_state),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .irq_tx_warn(irq_tx_warn), .irq_rx_warn(irq_rx_warn),
    .irq_bus_off(irq_bus_off), .irq_err(irq_err)
  );

  function automatic logic [31:0] put(logic [31:0] v, int n, logic b);
    logic [31:0] r = v;
    r[31-n] = b;
    return r;
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] v = 32'h0;
    v = put(v, 14, m_tw);
    v = put(v, 15, m_rw);
    for (int i = 0; i < 6; i++) v = put(v, 16 + i, m_err[i]);
    v = put(v, 22, m_txw);
    v = put(v, 23, m_rxw);
    v = put(v, 24, idle);
    v = put(v, 25, txrx);
    v = put(v, 26, fault_state[1]);
    v = put(v, 27, fault_state[0]);
    v = put(v, 29, m_bo);
    v = put(v, 30, m_er);
    return v;
  endfunction

  function automatic logic [31:0] exp_read();
    if (bus_addr == 8'h20) return exp_stat();
    if (bus_addr == 8'h1C) return {16'h0, rx_err_cnt, tx_err_cnt};
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic rd, wr;
    #1;
    if (bus_sel && !bus_wr) chk(tag, bus_rdata, exp_read());
    chk({tag, " irq R8 R9 R10"}, {28'h0, irq_tx_warn, irq_rx_warn, irq_bus_off, irq_err},
        {28'h0, m_tw, m_rw, m_bo, m_er});
    rd = bus_sel && !bus_wr && bus_addr == 8'h20;
    wr = bus_sel && bus_wr && bus_addr == 8'h20;
    m_tw  = (m_tw & !(wr && bus_wdata[31-14])) | (tx_warn & !p_tx);
    m_rw  = (m_rw & !(wr && bus_wdata[31-15])) | (rx_warn & !p_rx);
    m_bo  = (m_bo & !(wr && bus_wdata[31-29])) | (bus_off & !p_bo);
    m_er  = (m_er & !(wr && bus_wdata[31-30])) | (|err_evt);
    m_err = (rd ? 6'h0 : m_err) | err_evt;
    m_txw = (rd ? 1'b0 : m_txw) | tx_warn;
    m_rxw = (rd ? 1'b0 : m_rxw) | rx_warn;
    p_tx = tx_warn; p_rx = rx_warn; p_bo = bus_off;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; err_evt = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    cyc(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h20, "R1 status after reset");
    rd(8'h1C, "R1 counters after reset");

    rx_err_cnt = 8'hA5; tx_err_cnt = 8'h3C;
    rd(8'h1C, "R7 counter word");
    rd(8'h1C, "R7 counter read clears nothing");

    err_evt = 6'b000100; cyc("R2 pulse");
    cyc("R2 idle");
    rd(8'h20, "R2 R8 sticky ack error");
    rd(8'h20, "R3 cleared after read");

    err_evt = 6'b100001; cyc("R2 pulse pair");
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h20; err_evt = 6'b010000;
    cyc("R4 read collides with event");
    rd(8'h20, "R4 event survived read");

    err_evt = 6'b001010; cyc("R11 set");
    wr(8'h20, 32'h0, "R11 write zero");
    wr(8'h20, 32'hFFFF_FFFF & ~32'h2, "R11 write ones except err irq");
    rd(8'h24, "R11 unmapped read");
    rd(8'h20, "R11 flags kept after write");

    wr(8'h20, 32'h0, "R10 write zero keeps irq");
    wr(8'h20, 32'h2, "R10 clear err irq");
    err_evt = 6'b000001; bus_sel = 1; bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'h2;
    cyc("R10 set wins over clear");
    cyc("R10 after collision");

    tx_warn = 1; cyc("R9 tx warn rise");
    rd(8'h20, "R5 tx warn bit");
    rd(8'h20, "R4 R5 warn held while high");
    tx_warn = 0; rx_warn = 1; bus_off = 1; cyc("R9 rx warn and bus-off rise");
    rd(8'h20, "R5 after drop");
    wr(8'h20, 32'h0002_0004, "R10 clear tx warn and bus-off");
    rx_warn = 0; bus_off = 0;
    idle = 1; txrx = 1; fault_state = 2'b10;
    rd(8'h20, "R6 status fields");
    fault_state = 2'b01; txrx = 0;
    rd(8'h20, "R6 status fields swap");

    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 6; b++) err_evt[b] = ($urandom % 10) == 0;
      if (($urandom % 16) == 0) tx_warn = ~tx_warn;
      if (($urandom % 16) == 0) rx_warn = ~rx_warn;
      if (($urandom % 20) == 0) bus_off = ~bus_off;
      idle = $urandom; txrx = $urandom; fault_state = $urandom;
      rx_err_cnt = $urandom; tx_err_cnt = $urandom;
      bus_sel = ($urandom % 3) == 0;
      bus_wr = ($urandom % 3) == 0;
      case ($urandom % 6)
        0: bus_addr = 8'h1C;
        1: bus_addr = $urandom;
        default: bus_addr = 8'h20;
      endcase
      bus_wdata = $urandom;
      cyc("RND R2 R3 R4 R5 R6 R7 R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule